// File: doc/BRIEF.md
# Wrap-Aware Timer Priority Queue

This block keeps a small, always-sorted set of pending timers. Each timer has an identifier and a 16-bit expiry time. The entry due soonest is always shown at the head output. A single command port takes one operation per clock: add a timer, remove the head, change the expiry of a timer already held (re-arm), or idle. The result is visible at the head output one clock later.

Expiry times come from a free-running 16-bit counter, and that counter wraps. To keep the order correct across the wrap, the queue holds a boundary value. When a timer is added, it is tagged "late" if its expiry is numerically below the boundary. All late timers sort behind every timer that is not late. The boundary moves forward only on an idle cycle in which no stored timer is still in the early group. On that cycle the boundary takes the current time, and every stored timer is tagged early again.

A re-arm is carried out as a removal followed by an insertion in the same cycle. The cells close the gap left by the removed entry, and then open a gap at the new position. Nothing is re-sorted from scratch.

Top module: `tpq_timer_queue`

## Requirements
- R1: While reset is applied and just after it is released, the queue is empty, `head_vld_o` is 0 and `cmd_err_o` is 0. The boundary is 0.
- R2: Command codes on `cmd_op_i` are 0 for idle, 1 for insert, 2 for pop and 3 for re-arm. An accepted insert stores its entry. From the next cycle on, the head shows the stored entry with the smallest effective key, where the key is {late bit, priority}.
- R3: A pop on a non-empty queue removes the head entry. One cycle later the next-smallest entry is at the head and the occupancy has dropped by exactly one.
- R4: A command is rejected when it is an insert on a full queue, a pop on an empty queue, or a re-arm of an absent identifier on a full queue. A rejected command raises `cmd_err_o` for exactly one cycle, one cycle after the command, and leaves the contents unchanged. An accepted command gives `cmd_err_o` = 0.
- R5: A re-arm of a stored identifier removes its first occurrence and stores it again with the new priority. The occupancy does not change, and the command is accepted even when the queue is full.
- R6: A re-arm of an identifier that is not stored behaves exactly like an insert.
- R7: Entries with equal effective keys leave in the order they were stored. A re-armed entry counts as the newest.
- R8: An entry's late bit is 1 when its priority is below the boundary at the time it is stored. Every late entry sorts after every early entry, whatever its numeric priority.
- R9: On an idle cycle in which no stored entry is early, the boundary takes `now_i` and all stored late bits are cleared. Otherwise the boundary holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_op_i | input | 2 | Operation: 0 idle, 1 insert, 2 pop, 3 re-arm |
| cmd_id_i | input | ID_W | Timer identifier for insert and re-arm |
| cmd_prio_i | input | PRIO_W | Expiry priority for insert and re-arm |
| now_i | input | PRIO_W | Current timer count, used when the boundary advances |
| head_vld_o | output | 1 | Queue holds at least one entry |
| head_id_o | output | ID_W | Identifier of the head entry |
| head_prio_o | output | PRIO_W | Priority of the head entry |
| cmd_err_o | output | 1 | One-cycle pulse for a rejected command |

## Verification
The bench targets the wrap. It adds timers that sit on both sides of the boundary, and a design that compared raw priorities would put a freshly wrapped small value ahead of an older large one. It also re-arms a timer in a full queue and re-arms an absent identifier in a full queue. A design that handled occupancy wrongly would either drop a tail entry or wrongly accept the command. Runs of equal keys expose any design that does not keep entries in arrival order. A long random mix of commands, with the counter wrapping many times, is checked against a sorted-list model after every operation.

// File: rtl/tpq_pkg.sv
package tpq_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_INS  = 2'd1,
    OP_POP  = 2'd2,
    OP_RARM = 2'd3
  } tpq_op_e;
endpackage

// File: rtl/tpq_extract.sv
// Removal stage: closes the gap left by the first matching cell.
module tpq_extract #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ID_W   = 8,
  parameter int unsigned PRIO_W = 16
) (
  input  logic                          en_i,
  input  logic                          by_id_i,
  input  logic [ID_W-1:0]               key_id_i,
  input  logic [DEPTH-1:0]              in_vld_i,
  input  logic [DEPTH-1:0]              in_grp_i,
  input  logic [DEPTH-1:0][ID_W-1:0]    in_id_i,
  input  logic [DEPTH-1:0][PRIO_W-1:0]  in_prio_i,
  output logic [DEPTH-1:0]              out_vld_o,
  output logic [DEPTH-1:0]              out_grp_o,
  output logic [DEPTH-1:0][ID_W-1:0]    out_id_o,
  output logic [DEPTH-1:0][PRIO_W-1:0]  out_prio_o,
  output logic                          hit_o
);
  logic [DEPTH-1:0] match;
  logic [DEPTH-1:0] shift;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_cell
      if (g == 0) begin : g_first
        assign match[g] = en_i & in_vld_i[g] & (by_id_i ? (in_id_i[g] == key_id_i) : 1'b1);
        assign shift[g] = match[g];
      end else begin : g_rest
        assign match[g] = en_i & by_id_i & in_vld_i[g] & (in_id_i[g] == key_id_i);
        assign shift[g] = shift[g-1] | match[g];
      end
      if (g < DEPTH - 1) begin : g_pull
        assign out_vld_o[g]  = shift[g] ? in_vld_i[g+1]  : in_vld_i[g];
        assign out_grp_o[g]  = shift[g] ? in_grp_i[g+1]  : in_grp_i[g];
        assign out_id_o[g]   = shift[g] ? in_id_i[g+1]   : in_id_i[g];
        assign out_prio_o[g] = shift[g] ? in_prio_i[g+1] : in_prio_i[g];
      end else begin : g_tail
        assign out_vld_o[g]  = shift[g] ? 1'b0 : in_vld_i[g];
        assign out_grp_o[g]  = shift[g] ? 1'b0 : in_grp_i[g];
        assign out_id_o[g]   = shift[g] ? '0   : in_id_i[g];
        assign out_prio_o[g] = shift[g] ? '0   : in_prio_i[g];
      end
    end
  endgenerate

  assign hit_o = |match;
endmodule

// File: rtl/tpq_insert.sv
// Insertion stage: every cell compares its key with the new key and either
// keeps its entry, takes its lower neighbour's entry, or takes the new one.
module tpq_insert #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ID_W   = 8,
  parameter int unsigned PRIO_W = 16
) (
  input  logic                          en_i,
  input  logic                          new_grp_i,
  input  logic [ID_W-1:0]               new_id_i,
  input  logic [PRIO_W-1:0]             new_prio_i,
  input  logic [DEPTH-1:0]              in_vld_i,
  input  logic [DEPTH-1:0]              in_grp_i,
  input  logic [DEPTH-1:0][ID_W-1:0]    in_id_i,
  input  logic [DEPTH-1:0][PRIO_W-1:0]  in_prio_i,
  output logic [DEPTH-1:0]              out_vld_o,
  output logic [DEPTH-1:0]              out_grp_o,
  output logic [DEPTH-1:0][ID_W-1:0]    out_id_o,
  output logic [DEPTH-1:0][PRIO_W-1:0]  out_prio_o
);
  localparam int unsigned KEY_W = PRIO_W + 1;

  logic [KEY_W-1:0] new_key;
  logic [DEPTH-1:0] after;

  assign new_key = {new_grp_i, new_prio_i};

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_cell
      logic [KEY_W-1:0] cell_key;
      assign cell_key = {in_grp_i[g], in_prio_i[g]};
      // strictly greater keeps equal keys in arrival order
      assign after[g] = ~in_vld_i[g] | (cell_key > new_key);
      if (g == 0) begin : g_first
        logic place;
        assign place = en_i & after[g];
        assign out_vld_o[g]  = place ? 1'b1       : in_vld_i[g];
        assign out_grp_o[g]  = place ? new_grp_i  : in_grp_i[g];
        assign out_id_o[g]   = place ? new_id_i   : in_id_i[g];
        assign out_prio_o[g] = place ? new_prio_i : in_prio_i[g];
      end else begin : g_rest
        logic move;
        logic place;
        assign move  = en_i & after[g-1];
        assign place = en_i & after[g] & ~after[g-1];
        assign out_vld_o[g]  = move ? in_vld_i[g-1]  : (place ? 1'b1       : in_vld_i[g]);
        assign out_grp_o[g]  = move ? in_grp_i[g-1]  : (place ? new_grp_i  : in_grp_i[g]);
        assign out_id_o[g]   = move ? in_id_i[g-1]   : (place ? new_id_i   : in_id_i[g]);
        assign out_prio_o[g] = move ? in_prio_i[g-1] : (place ? new_prio_i : in_prio_i[g]);
      end
    end
  endgenerate
endmodule

// File: rtl/tpq_timer_queue.sv
module tpq_timer_queue #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ID_W   = 8,
  parameter int unsigned PRIO_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cmd_op_i,
  input  logic [ID_W-1:0]   cmd_id_i,
  input  logic [PRIO_W-1:0] cmd_prio_i,
  input  logic [PRIO_W-1:0] now_i,
  output logic              head_vld_o,
  output logic [ID_W-1:0]   head_id_o,
  output logic [PRIO_W-1:0] head_prio_o,
  output logic              cmd_err_o
);
  import tpq_pkg::*;

  localparam int unsigned SYNC_N = 2;

  // reset: asserted asynchronously, released on the clock
  logic [SYNC_N-1:0] rst_pipe;
  logic              rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_N-2:0], 1'b1};
  end
  assign rst_sn = rst_pipe[SYNC_N-1];

  tpq_op_e op;
  assign op = tpq_op_e'(cmd_op_i);

  logic [DEPTH-1:0]             q_vld, q_grp;
  logic [DEPTH-1:0][ID_W-1:0]   q_id;
  logic [DEPTH-1:0][PRIO_W-1:0] q_prio;
  logic [PRIO_W-1:0]            bound_r;
  logic                         err_r;

  logic [DEPTH-1:0]             x_vld, x_grp;
  logic [DEPTH-1:0][ID_W-1:0]   x_id;
  logic [DEPTH-1:0][PRIO_W-1:0] x_prio;
  logic [DEPTH-1:0]             i_vld, i_grp;
  logic [DEPTH-1:0][ID_W-1:0]   i_id;
  logic [DEPTH-1:0][PRIO_W-1:0] i_prio;

  logic full, empty, hit, rm_en, ins_en, new_grp, advance, q_en;
  logic [DEPTH-1:0]             n_vld, n_grp;
  logic [DEPTH-1:0][ID_W-1:0]   n_id;
  logic [DEPTH-1:0][PRIO_W-1:0] n_prio;
  logic [PRIO_W-1:0]            bound_n;
  logic                         err_n;

  assign full    = q_vld[DEPTH-1];
  assign empty   = ~q_vld[0];
  assign rm_en   = ((op == OP_POP) & ~empty) | (op == OP_RARM);
  assign new_grp = cmd_prio_i < bound_r;
  assign advance = (op == OP_IDLE) & ~|(q_vld & ~q_grp);

  tpq_extract #(.DEPTH(DEPTH), .ID_W(ID_W), .PRIO_W(PRIO_W)) u_extract (
    .en_i      (rm_en),
    .by_id_i   (op == OP_RARM),
    .key_id_i  (cmd_id_i),
    .in_vld_i  (q_vld),
    .in_grp_i  (q_grp),
    .in_id_i   (q_id),
    .in_prio_i (q_prio),
    .out_vld_o (x_vld),
    .out_grp_o (x_grp),
    .out_id_o  (x_id),
    .out_prio_o(x_prio),
    .hit_o     (hit)
  );

  assign ins_en = ((op == OP_INS) & ~full) | ((op == OP_RARM) & (hit | ~full));

  tpq_insert #(.DEPTH(DEPTH), .ID_W(ID_W), .PRIO_W(PRIO_W)) u_insert (
    .en_i      (ins_en),
    .new_grp_i (new_grp),
    .new_id_i  (cmd_id_i),
    .new_prio_i(cmd_prio_i),
    .in_vld_i  (x_vld),
    .in_grp_i  (x_grp),
    .in_id_i   (x_id),
    .in_prio_i (x_prio),
    .out_vld_o (i_vld),
    .out_grp_o (i_grp),
    .out_id_o  (i_id),
    .out_prio_o(i_prio)
  );

  // next-state
  always_comb begin
    n_vld   = i_vld;
    n_grp   = advance ? '0 : i_grp;
    n_id    = i_id;
    n_prio  = i_prio;
    bound_n = advance ? now_i : bound_r;
    err_n   = ((op == OP_INS) & full) | ((op == OP_POP) & empty) |
              ((op == OP_RARM) & ~hit & full);
    q_en    = (op != OP_IDLE) | advance;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      q_vld   <= '0;
      q_grp   <= '0;
      q_id    <= '0;
      q_prio  <= '0;
      bound_r <= '0;
      err_r   <= 1'b0;
    end else begin
      err_r <= err_n;
      if (q_en) begin
        q_vld   <= n_vld;
        q_grp   <= n_grp;
        q_id    <= n_id;
        q_prio  <= n_prio;
        bound_r <= bound_n;
      end
    end
  end

  assign head_vld_o  = q_vld[0];
  assign head_id_o   = q_id[0];
  assign head_prio_o = q_prio[0];
  assign cmd_err_o   = err_r;

  // R4
  ins_full_reject_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (op == OP_INS && q_vld[DEPTH-1]) |=> (cmd_err_o && $stable(q_vld) && $stable(q_prio) && $stable(q_id)));
  // R4
  pop_empty_reject_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (op == OP_POP && !q_vld[0]) |=> (cmd_err_o && !head_vld_o));
  // R3
  pop_count_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (op == OP_POP && q_vld[0]) |=> ($countones(q_vld) == $past($countones(q_vld)) - 1 && !cmd_err_o));
  // R2
  ins_count_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (op == OP_INS && !q_vld[DEPTH-1]) |=> ($countones(q_vld) == $past($countones(q_vld)) + 1));
  // R5
  rearm_full_count_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (op == OP_RARM && q_vld[DEPTH-1]) |=> $stable(q_vld));
  // R9
  advance_clear_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (op == OP_IDLE && !(|(q_vld & ~q_grp))) |=> (q_grp == '0 && bound_r == $past(now_i)));
  // R9
  bound_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (op != OP_IDLE) |=> $stable(bound_r));

  genvar g;
  generate
    for (g = 0; g < DEPTH - 1; g++) begin : g_ord
      // R8
      sorted_order_chk: assert property (@(posedge clk) disable iff (!rst_sn)
        q_vld[g+1] |-> (q_vld[g] && ({q_grp[g], q_prio[g]} <= {q_grp[g+1], q_prio[g+1]})));
    end
  endgenerate
endmodule

// File: tb/tpq_timer_queue_bench.sv
`timescale 1ns/1ps
module tpq_timer_queue_bench;
  localparam int DEPTH  = 4;
  localparam int ID_W   = 8;
  localparam int PRIO_W = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [1:0]        cmd_op_i;
  logic [ID_W-1:0]   cmd_id_i;
  logic [PRIO_W-1:0] cmd_prio_i;
  logic [PRIO_W-1:0] now_i;
  logic              head_vld_o;
  logic [ID_W-1:0]   head_id_o;
  logic [PRIO_W-1:0] head_prio_o;
  logic              cmd_err_o;

  always #2 clk = ~clk;

  tpq_timer_queue #(.DEPTH(DEPTH), .ID_W(ID_W), .PRIO_W(PRIO_W)) u_tpq_timer_queue (
    .clk(clk), .rst_n(rst_n), .cmd_op_i(cmd_op_i), .cmd_id_i(cmd_id_i),
    .cmd_prio_i(cmd_prio_i), .now_i(now_i), .head_vld_o(head_vld_o),
    .head_id_o(head_id_o), .head_prio_o(head_prio_o), .cmd_err_o(cmd_err_o)
  );

  typedef struct { bit grp; int id; int prio; } ent_t;
  typedef struct { bit err; bit vld; int id; int prio; string req; } exp_t;

  ent_t model[$];
  exp_t expq[$];
  int   mbound = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  function automatic int keyof(ent_t e);
    return (int'(e.grp) << PRIO_W) | e.prio;
  endfunction

  function automatic void m_store(int id, int prio);
    ent_t e;
    int   pos;
    e.grp  = (prio < mbound);
    e.id   = id;
    e.prio = prio;
    pos = model.size();
    for (int i = 0; i < model.size(); i++)
      if (keyof(model[i]) > keyof(e)) begin pos = i; break; end
    model.insert(pos, e);
  endfunction

  // driver: applies one command, updates the model, posts the expectation
  task automatic do_op(input int op, input int id, input int prio, input int now, input string req);
    exp_t x;
    int   idx;
    bit   err = 1'b0;
    @(negedge clk);
    cmd_op_i   = op[1:0];
    cmd_id_i   = id[ID_W-1:0];
    cmd_prio_i = prio[PRIO_W-1:0];
    now_i      = now[PRIO_W-1:0];
    case (op)
      0: begin
        bit any_early = 1'b0;
        foreach (model[i]) if (!model[i].grp) any_early = 1'b1;
        if (!any_early) begin
          mbound = now & 16'hFFFF;
          foreach (model[i]) model[i].grp = 1'b0;
        end
      end
      1: if (model.size() == DEPTH) err = 1'b1; else m_store(id, prio);
      2: if (model.size() == 0) err = 1'b1; else void'(model.pop_front());
      default: begin
        idx = -1;
        foreach (model[i]) if (idx < 0 && model[i].id == id) idx = i;
        if (idx >= 0) begin model.delete(idx); m_store(id, prio); end
        else if (model.size() == DEPTH) err = 1'b1;
        else m_store(id, prio);
      end
    endcase
    @(posedge clk);
    #1;
    x.err = err;
    x.vld = model.size() > 0;
    x.id  = x.vld ? model[0].id : 0;
    x.prio = x.vld ? model[0].prio : 0;
    x.req = req;
    expq.push_back(x);
  endtask

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp_v);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (expq.size() > 0) begin
      exp_t e;
      e = expq.pop_front();
      chk(cmd_err_o == e.err, e.req, "err", int'(cmd_err_o), int'(e.err));
      chk(head_vld_o == e.vld, e.req, "head_vld", int'(head_vld_o), int'(e.vld));
      if (e.vld) begin
        chk(int'(head_id_o) == e.id, e.req, "head_id", int'(head_id_o), e.id);
        chk(int'(head_prio_o) == e.prio, e.req, "head_prio", int'(head_prio_o), e.prio);
      end
    end
  end

  task automatic finish_up();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_up();
    end
  end

  initial begin
    int now;
    rst_n = 1'b0;
    cmd_op_i = 2'd0; cmd_id_i = '0; cmd_prio_i = '0; now_i = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(head_vld_o == 1'b0 && cmd_err_o == 1'b0, "R1", "reset outputs", int'({head_vld_o, cmd_err_o}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(head_vld_o == 1'b0 && cmd_err_o == 1'b0, "R1", "after release", int'({head_vld_o, cmd_err_o}), 0);

    // R2 ordering on insert
    do_op(1, 1, 300, 0, "R2");
    do_op(1, 2, 100, 0, "R2");
    do_op(1, 3, 200, 0, "R2");
    // R3 pops
    do_op(2, 0, 0, 0, "R3");
    do_op(2, 0, 0, 0, "R3");
    do_op(2, 0, 0, 0, "R3");
    // R4 pop on empty
    do_op(2, 0, 0, 0, "R4");
    // R4 insert on full
    do_op(1, 4, 40, 0, "R2");
    do_op(1, 5, 50, 0, "R2");
    do_op(1, 6, 60, 0, "R2");
    do_op(1, 7, 70, 0, "R2");
    do_op(1, 8, 10, 0, "R4");
    // R5 re-arm in full queue moves tail to head, then head to tail
    do_op(3, 7, 5, 0, "R5");
    do_op(3, 7, 90, 0, "R5");
    // R4 re-arm of absent id while full
    do_op(3, 9, 1, 0, "R4");
    repeat (4) do_op(2, 0, 0, 0, "R3");
    // R7 equal keys keep arrival order, re-armed entry counts newest
    do_op(1, 10, 500, 0, "R7");
    do_op(1, 11, 500, 0, "R7");
    do_op(1, 12, 500, 0, "R7");
    do_op(3, 10, 500, 0, "R7");
    do_op(2, 0, 0, 0, "R7");
    // R6 re-arm of absent id acts as insert
    do_op(3, 20, 400, 0, "R6");
    repeat (4) do_op(2, 0, 0, 0, "R3");
    // R8/R9 wrap handling
    do_op(0, 0, 0, 16'hF000, "R9");
    do_op(1, 30, 16'hF100, 16'hF000, "R8");
    do_op(1, 31, 16'h0010, 16'hF000, "R8");
    do_op(0, 0, 0, 16'h0020, "R9");
    do_op(2, 0, 0, 16'h0020, "R8");
    do_op(0, 0, 0, 16'h0020, "R9");
    do_op(1, 32, 16'h0005, 16'h0020, "R8");
    do_op(2, 0, 0, 16'h0020, "R8");
    do_op(2, 0, 0, 16'h0020, "R3");

    // random mix across many counter wraps
    now = 16'h0020;
    for (int n = 0; n < 3000; n++) begin
      int op;
      int r;
      r = int'($urandom_range(0, 9));
      op = (r < 3) ? 0 : (r < 6) ? 1 : (r < 8) ? 2 : 3;
      now = (now + int'($urandom_range(0, 3000))) & 16'hFFFF;
      do_op(op, int'($urandom_range(0, 11)),
            (now + int'($urandom_range(0, 20000))) & 16'hFFFF, now,
            (op == 3) ? "R5" : (op == 0) ? "R9" : "R2");
    end
    @(negedge clk);
    @(negedge clk);
    finish_up();
  end
endmodule